// File: doc/BRIEF.md
# Four-Bit Mode-Selected ALU

This block is a small arithmetic-logic unit for two 4-bit operands. Two select inputs choose the operation: addition with carry, bitwise OR, bitwise AND, or bitwise XOR. The result and the carry-out are registered, so they change on the rising clock edge that follows the operands and selects being applied.

The carry input is used only by the addition. In the three logic operations it is ignored and the carry-out is held at 0. An active-low asynchronous reset clears both registered outputs.

Top module: `alu4_mode`

## Requirements
- R1: While `rst_ni` is low, `s_o` and `co_o` are both 0.
- R2: With `sel0_i`=0 and `sel1_i`=0, the outputs become `{co_o, s_o}` = `a_i + b_i + carry_i`. The sum is formed 5 bits wide on zero-extended operands, and `co_o` is its bit 4.
- R3: With `sel0_i`=0 and `sel1_i`=1, `s_o` becomes `a_i | b_i`.
- R4: With `sel0_i`=1 and `sel1_i`=0, `s_o` becomes `a_i & b_i`.
- R5: With `sel0_i`=1 and `sel1_i`=1, `s_o` becomes `a_i ^ b_i`.
- R6: In the three logic operations, `co_o` is 0 and `carry_i` has no effect on `s_o`.
- R7: The outputs change only on a rising clock edge. Inputs applied between two edges show up after the next edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| carry_i | input | 1 | Carry into the addition |
| sel0_i | input | 1 | Operation select, high bit of the encoding |
| sel1_i | input | 1 | Operation select, low bit of the encoding |
| s_o | output | 4 | Registered result |
| co_o | output | 1 | Registered carry-out, used by addition only |

## Verification
A wrong decode of the select pair shows up as the wrong operation's result on `s_o`, one edge after the inputs are applied. A break in the carry chain corrupts a high bit of the sum, or `co_o`, only for operands whose carries travel that far, so the bench mixes random vectors with full-propagate cases such as 15+0 with carry-in. A carry that leaks into a logic operation shows up at once as `co_o`=1, or as a changed `s_o`, when `carry_i` is toggled.

// File: rtl/alu4_pkg.sv
`timescale 1ns/1ps
package alu4_pkg;
  localparam int unsigned DATA_W = 4;

  // encoding is {sel0, sel1}
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_OR  = 2'b01,
    OP_AND = 2'b10,
    OP_XOR = 2'b11
  } op_e;
endpackage

// File: rtl/alu4_decode.sv
`timescale 1ns/1ps
module alu4_decode
  import alu4_pkg::*;
(
  input  logic sel0_i,
  input  logic sel1_i,
  output op_e  op_o
);
  always_comb begin
    unique case ({sel0_i, sel1_i})
      2'b00:   op_o = OP_ADD;
      2'b01:   op_o = OP_OR;
      2'b10:   op_o = OP_AND;
      default: op_o = OP_XOR;
    endcase
  end
endmodule

// File: rtl/alu4_adder.sv
`timescale 1ns/1ps
module alu4_adder #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = c[W];
endmodule

// File: rtl/alu4_logic.sv
`timescale 1ns/1ps
module alu4_logic #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] or_o,
  output logic [W-1:0] and_o,
  output logic [W-1:0] xor_o
);
  assign or_o  = a_i | b_i;
  assign and_o = a_i & b_i;
  assign xor_o = a_i ^ b_i;
endmodule

// File: rtl/alu4_mode.sv
`timescale 1ns/1ps
module alu4_mode
  import alu4_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic         sel0_i,
  input  logic         sel1_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  op_e         op;
  logic [W-1:0] sum, or_v, and_v, xor_v;
  logic         cout;
  logic [W-1:0] res_d;
  logic         co_d;

  alu4_decode u_dec (.sel0_i(sel0_i), .sel1_i(sel1_i), .op_o(op));

  alu4_adder #(.W(W)) u_add (
    .a_i(a_i), .b_i(b_i), .cin_i(carry_i), .sum_o(sum), .cout_o(cout)
  );

  alu4_logic #(.W(W)) u_log (
    .a_i(a_i), .b_i(b_i), .or_o(or_v), .and_o(and_v), .xor_o(xor_v)
  );

  always_comb begin
    co_d = 1'b0;
    unique case (op)
      OP_ADD: begin res_d = sum; co_d = cout; end
      OP_OR:  res_d = or_v;
      OP_AND: res_d = and_v;
      default: res_d = xor_v;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_o  <= '0;
      co_o <= 1'b0;
    end else begin
      s_o  <= res_d;
      co_o <= co_d;
    end
  end

  // R2
  add_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel0_i && !sel1_i) |=> ({co_o, s_o} ==
      ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{W{1'b0}}, $past(carry_i)})));
  // R3
  or_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel0_i && sel1_i) |=> (s_o == ($past(a_i) | $past(b_i))));
  // R4
  and_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel0_i && !sel1_i) |=> (s_o == ($past(a_i) & $past(b_i))));
  // R5
  xor_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel0_i && sel1_i) |=> (s_o == ($past(a_i) ^ $past(b_i))));
  // R6
  logic_no_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel0_i || sel1_i) |=> !co_o);
endmodule

// File: tb/alu4_mode_tb.sv
`timescale 1ns/1ps
module alu4_mode_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] a = '0, b = '0;
  logic       ci = 1'b0, s0 = 1'b0, s1 = 1'b0;
  logic [3:0] s;
  logic       co;
  int unsigned n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu4_mode u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .carry_i(ci),
    .sel0_i(s0), .sel1_i(s1), .s_o(s), .co_o(co)
  );

  function automatic logic [4:0] model(input logic [3:0] x, input logic [3:0] y,
                                       input logic c, input logic m0, input logic m1);
    case ({m0, m1})
      2'b00:   return {1'b0, x} + {1'b0, y} + {4'b0, c};
      2'b01:   return {1'b0, x | y};
      2'b10:   return {1'b0, x & y};
      default: return {1'b0, x ^ y};
    endcase
  endfunction

  function automatic string req_of(input logic m0, input logic m1);
    case ({m0, m1})
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got co,s=%b expected %b", req, got, exp);
    end
  endtask

  // drive at negedge, sample at following negedge (one register)
  task automatic apply(input logic [3:0] x, input logic [3:0] y,
                       input logic c, input logic m0, input logic m1);
    @(negedge clk);
    a = x; b = y; ci = c; s0 = m0; s1 = m1;
    @(negedge clk);
    check(req_of(m0, m1), {co, s}, model(x, y, c, m0, m1));
    if (m0 | m1) check("R6", {4'b0, co}, 5'b0);
  endtask

  initial begin
    logic [4:0] held;
    void'($urandom(32'd20140116));
    repeat (3) @(negedge clk);
    check("R1", {co, s}, 5'b0);
    rst_n = 1'b1;

    // directed corners
    apply(4'hF, 4'hF, 1'b1, 0, 0);   // R2 31 -> co=1,s=F
    apply(4'hF, 4'h0, 1'b1, 0, 0);   // R2 full propagate
    apply(4'h0, 4'h0, 1'b0, 0, 0);   // R2 zero
    apply(4'h8, 4'h8, 1'b0, 0, 0);   // R2 carry out only
    apply(4'hA, 4'h5, 1'b1, 0, 1);   // R3
    apply(4'hC, 4'hA, 1'b1, 1, 0);   // R4
    apply(4'hC, 4'hA, 1'b1, 1, 1);   // R5
    apply(4'hF, 4'hF, 1'b1, 1, 1);   // R6 no carry leak

    // R6: carry_i toggled in logic modes leaves outputs unchanged
    for (int m = 1; m < 4; m++) begin
      apply(4'h9, 4'h7, 1'b0, m[1], m[0]);
      held = {co, s};
      apply(4'h9, 4'h7, 1'b1, m[1], m[0]);
      check("R6", {co, s}, held);
    end

    // R7: outputs hold until the next rising edge
    apply(4'h3, 4'h4, 1'b0, 0, 0);
    @(negedge clk);
    a = 4'hF; b = 4'h1; ci = 1'b1; s0 = 1'b1; s1 = 1'b1;
    #1;
    check("R7", {co, s}, 5'd7);
    @(negedge clk);
    check("R7", {co, s}, {1'b0, 4'hE});

    // random
    for (int i = 0; i < 300; i++) begin
      apply(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // R1: reset mid-run clears outputs
    apply(4'hF, 4'hF, 1'b1, 0, 0);
    rst_n = 1'b0;
    #1;
    check("R1", {co, s}, 5'b0);
    @(negedge clk);
    check("R1", {co, s}, 5'b0);
    rst_n = 1'b1;
    apply(4'h6, 4'h3, 1'b0, 1, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule